// File: doc/BRIEF.md
# Shared Cipher Data Buffer

This block is the data staging area that sits in front of a block-cipher engine. It holds four 32-bit words that serve both as the input block and, once the engine is done, as the output block. The host reaches all four words through one data port. A small word pointer decides which word the next access touches. The pointer steps forward after every accepted write and every read, and software can also load it directly.

A start pulse hands the current 128-bit contents to the engine and marks the buffer busy. A result strobe from the engine writes the processed block back over the same four words, clears the busy state and raises a completion flag. The flag drops by itself once the host has read every output word that matters for the selected chaining mode and feedback segment size. The interrupt request is the flag gated by an enable input.

Host writes use a valid/ready handshake. The buffer withholds ready for the whole time the engine is busy, so a writer holding valid simply stalls. Reads and pointer loads are plain single-cycle strobes, and the engine side is a bare start/result pair.

Top module: `cipher_data_buffer`

## Requirements
- R1: After reset the pointer is 0, the completion flag and the interrupt request are low, and all four words read back as zero.
- R2: A write with wr_valid and wr_ready both high stores wr_data into the word selected by the pointer and advances the pointer by one, wrapping from 3 to 0.
- R3: rd_data always shows the word selected by the pointer. A cycle with rd_req high advances the pointer by one, wrapping from 3 to 0.
- R4: A cycle with ptr_load high sets the pointer to ptr_value. If a write or read happens in that same cycle, it uses the old pointer, and the loaded value takes precedence over the step.
- R5: While busy, wr_ready is low. A write presented in that time changes neither any word nor the pointer.
- R6: start while idle produces an eng_start pulse in that cycle, with eng_block holding the words (word i at bits 32i+31:32i), and sets busy. start while busy is ignored.
- R7: eng_done loads eng_result into the four words with the same bit layout, clears busy, and sets the completion flag in the following cycle.
- R8: The relevant output words are fixed by mode and segment size. Mode codes are 0 ECB, 1 CBC, 2 OFB, 3 CFB and 4 CTR. Segment codes are 0 = 128, 1 = 64, 2 = 32, 3 = 16 and 4 = 8 bits. All four words are relevant except in CFB: there, segment 1 makes words 0 and 1 relevant, and segments 2 to 4 make only word 0 relevant. The flag clears one cycle after the read that completes the relevant set, in any order.
- R9: Reads of words outside the relevant set, and repeated reads of an already-read word, do not clear the flag. The record of words read is emptied when a new result is loaded.
- R10: irq equals the completion flag ANDed with irq_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | Host write data valid |
| wr_ready | output | 1 | Buffer accepts a write (not busy) |
| wr_data | input | 32 | Host write word |
| rd_req | input | 1 | Host read strobe, advances the pointer |
| rd_data | output | 32 | Word at the pointer |
| ptr_load | input | 1 | Load the pointer from ptr_value |
| ptr_value | input | 2 | Value for a pointer load |
| ptr | output | 2 | Current word pointer |
| mode | input | 3 | Chaining mode code |
| seg_size | input | 3 | Feedback segment size code |
| start | input | 1 | Request to process the buffered block |
| busy | output | 1 | Engine holds the block |
| eng_start | output | 1 | Start pulse to the engine |
| eng_block | output | 128 | Block handed to the engine |
| eng_done | input | 1 | Engine result strobe |
| eng_result | input | 128 | Processed block from the engine |
| done_flag | output | 1 | Completion flag |
| irq_en | input | 1 | Interrupt enable |
| irq | output | 1 | Interrupt request |

## Verification
Two functions can fall in the same cycle here: a direct pointer load and a data access, either a write or a read. The bench provokes this by raising ptr_load together with wr_valid, and separately together with rd_req. It judges the outcome by reading the words back, which shows that the access went to the old word and that the next access starts at the loaded position. It also sweeps every mode and segment combination, reading the words out of order, so that the read closing the relevant set is checked against the exact cycle in which the flag falls.

// File: rtl/cdb_pkg.sv
package cdb_pkg;
  localparam int CDB_WORDS = 4;

  typedef enum logic [2:0] {
    CM_ECB = 3'd0,
    CM_CBC = 3'd1,
    CM_OFB = 3'd2,
    CM_CFB = 3'd3,
    CM_CTR = 3'd4
  } chain_mode_e;

  typedef enum logic [2:0] {
    SEG_128 = 3'd0,
    SEG_64  = 3'd1,
    SEG_32  = 3'd2,
    SEG_16  = 3'd3,
    SEG_8   = 3'd4
  } seg_size_e;

  // Words whose read-out is required before the completion flag may drop.
  function automatic logic [CDB_WORDS-1:0] relevant_words(logic [2:0] m, logic [2:0] s);
    logic [CDB_WORDS-1:0] r;
    r = '1;
    if (m == CM_CFB) begin
      if (s == SEG_64)
        r = CDB_WORDS'(4'b0011);
      else if (s != SEG_128)
        r = CDB_WORDS'(4'b0001);
    end
    return r;
  endfunction
endpackage

// File: rtl/cdb_ptr.sv
module cdb_ptr #(
  parameter int N_WORDS = 4,
  localparam int PTR_W = $clog2(N_WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             load,
  input  logic [PTR_W-1:0] load_val,
  output logic [PTR_W-1:0] ptr
);
  logic [PTR_W-1:0] ptr_next;

  always_comb begin
    ptr_next = ptr;
    if (load)
      ptr_next = load_val;
    else if (step)
      ptr_next = (ptr == PTR_W'(N_WORDS-1)) ? '0 : ptr + PTR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr <= '0;
    else        ptr <= ptr_next;
  end
endmodule

// File: rtl/cdb_store.sv
module cdb_store #(
  parameter int WORD_W  = 32,
  parameter int N_WORDS = 4,
  localparam int PTR_W = $clog2(N_WORDS),
  localparam int BLK_W = WORD_W * N_WORDS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [PTR_W-1:0]  wr_sel,
  input  logic [WORD_W-1:0] wr_word,
  input  logic              blk_load,
  input  logic [BLK_W-1:0]  blk_in,
  input  logic [PTR_W-1:0]  rd_sel,
  output logic [WORD_W-1:0] rd_word,
  output logic [BLK_W-1:0]  blk_out
);
  logic [WORD_W-1:0] words [N_WORDS];

  for (genvar i = 0; i < N_WORDS; i++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        words[i] <= '0;
      else if (blk_load)
        words[i] <= blk_in[i*WORD_W +: WORD_W];
      else if (wr_en && wr_sel == PTR_W'(i))
        words[i] <= wr_word;
    end
    assign blk_out[i*WORD_W +: WORD_W] = words[i];
  end

  assign rd_word = words[rd_sel];
endmodule

// File: rtl/cdb_track.sv
module cdb_track #(
  parameter int N_WORDS = 4,
  localparam int PTR_W = $clog2(N_WORDS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               result_in,
  input  logic               rd_fire,
  input  logic [PTR_W-1:0]   rd_sel,
  input  logic [N_WORDS-1:0] relevant,
  output logic               flag
);
  logic [N_WORDS-1:0] seen;
  logic [N_WORDS-1:0] seen_next;
  logic [N_WORDS-1:0] hit;

  always_comb begin
    hit = '0;
    if (rd_fire && flag) hit[rd_sel] = 1'b1;
    seen_next = seen | hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen <= '0;
      flag <= 1'b0;
    end else if (result_in) begin
      seen <= '0;
      flag <= 1'b1;
    end else if (flag) begin
      seen <= seen_next;
      if ((seen_next & relevant) == relevant) flag <= 1'b0;
    end
  end
endmodule

// File: rtl/cipher_data_buffer.sv
module cipher_data_buffer
  import cdb_pkg::*;
#(
  parameter int WORD_W = 32,
  localparam int N_WORDS = CDB_WORDS,
  localparam int PTR_W = $clog2(N_WORDS),
  localparam int BLK_W = WORD_W * N_WORDS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              rd_req,
  output logic [WORD_W-1:0] rd_data,
  input  logic              ptr_load,
  input  logic [PTR_W-1:0]  ptr_value,
  output logic [PTR_W-1:0]  ptr,
  input  logic [2:0]        mode,
  input  logic [2:0]        seg_size,
  input  logic              start,
  output logic              busy,
  output logic              eng_start,
  output logic [BLK_W-1:0]  eng_block,
  input  logic              eng_done,
  input  logic [BLK_W-1:0]  eng_result,
  output logic              done_flag,
  input  logic              irq_en,
  output logic              irq
);
  logic wr_fire;

  assign wr_ready  = ~busy;
  assign wr_fire   = wr_valid & wr_ready;
  assign eng_start = start & ~busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         busy <= 1'b0;
    else if (eng_done)  busy <= 1'b0;
    else if (eng_start) busy <= 1'b1;
  end

  cdb_ptr #(.N_WORDS(N_WORDS)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (wr_fire | rd_req),
    .load     (ptr_load),
    .load_val (ptr_value),
    .ptr      (ptr)
  );

  cdb_store #(.WORD_W(WORD_W), .N_WORDS(N_WORDS)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_fire),
    .wr_sel   (ptr),
    .wr_word  (wr_data),
    .blk_load (eng_done),
    .blk_in   (eng_result),
    .rd_sel   (ptr),
    .rd_word  (rd_data),
    .blk_out  (eng_block)
  );

  cdb_track #(.N_WORDS(N_WORDS)) u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .result_in (eng_done),
    .rd_fire   (rd_req),
    .rd_sel    (ptr),
    .relevant  (relevant_words(mode, seg_size)),
    .flag      (done_flag)
  );

  assign irq = done_flag & irq_en;
endmodule

// File: rtl/cipher_data_buffer_chk.sv
module cipher_data_buffer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_valid,
  input logic       wr_ready,
  input logic       rd_req,
  input logic       ptr_load,
  input logic [1:0] ptr_value,
  input logic [1:0] ptr,
  input logic       start,
  input logic       busy,
  input logic       eng_start,
  input logic       eng_done,
  input logic       done_flag,
  input logic       irq
);
  // R2
  step_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && !ptr_load) |=> ptr == 2'($past(ptr) + 2'd1));

  // R4
  load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_load |=> ptr == $past(ptr_value));

  // R5
  busy_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_valid && !rd_req && !ptr_load) |=> $stable(ptr));

  // R6
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_start && !eng_done) |=> busy);

  // R6
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !eng_start);

  // R7
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_done |=> (done_flag && !busy));

  // R10
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> done_flag);
endmodule

bind cipher_data_buffer cipher_data_buffer_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_valid  (wr_valid),
  .wr_ready  (wr_ready),
  .rd_req    (rd_req),
  .ptr_load  (ptr_load),
  .ptr_value (ptr_value),
  .ptr       (ptr),
  .start     (start),
  .busy      (busy),
  .eng_start (eng_start),
  .eng_done  (eng_done),
  .done_flag (done_flag),
  .irq       (irq)
);

// File: tb/cipher_data_buffer_tb.sv
module cipher_data_buffer_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_valid = 1'b0;
  logic         wr_ready;
  logic [31:0]  wr_data = '0;
  logic         rd_req = 1'b0;
  logic [31:0]  rd_data;
  logic         ptr_load = 1'b0;
  logic [1:0]   ptr_value = '0;
  logic [1:0]   ptr;
  logic [2:0]   mode = '0;
  logic [2:0]   seg_size = '0;
  logic         start = 1'b0;
  logic         busy;
  logic         eng_start;
  logic [127:0] eng_block;
  logic         eng_done = 1'b0;
  logic [127:0] eng_result = '0;
  logic         done_flag;
  logic         irq_en = 1'b0;
  logic         irq;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  cipher_data_buffer u_dut (.*);

  task automatic check(string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      summary();
    end
  end

  task automatic set_ptr(logic [1:0] v);
    @(negedge clk); ptr_load = 1'b1; ptr_value = v;
    @(negedge clk); ptr_load = 1'b0;
  endtask

  task automatic write_word(logic [31:0] d);
    @(negedge clk); wr_valid = 1'b1; wr_data = d;
    @(negedge clk); wr_valid = 1'b0;
  endtask

  // Checks rd_data against exp, then issues the read strobe.
  task automatic read_word(string req, logic [31:0] exp);
    @(negedge clk);
    check(req, rd_data, exp);
    rd_req = 1'b1;
    @(negedge clk); rd_req = 1'b0;
  endtask

  function automatic logic [3:0] rel_model(int m, int s);
    if (m == 3 && s == 1) return 4'b0011;
    if (m == 3 && s >= 2) return 4'b0001;
    return 4'b1111;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 ptr", ptr, 0);
    check("R1 flag", done_flag, 0);
    check("R1 irq", irq, 0);
    for (int i = 0; i < 4; i++) read_word("R1 zero word", 32'h0);
    // R3 wrap after four reads
    check("R3 wrap", ptr, 0);

    // R4 collision: write and load in the same cycle
    set_ptr(2'd1);
    @(negedge clk); wr_valid = 1'b1; wr_data = 32'hA5A5_0001; ptr_load = 1'b1; ptr_value = 2'd3;
    @(negedge clk); wr_valid = 1'b0; ptr_load = 1'b0;
    check("R4 write+load ptr", ptr, 3);
    set_ptr(2'd1);
    read_word("R4 write used old ptr", 32'hA5A5_0001);
    check("R4 word3 untouched", eng_block[127:96], 0);
    // R4 collision: read and load in the same cycle
    set_ptr(2'd1);
    @(negedge clk);
    check("R4 read data", rd_data, 32'hA5A5_0001);
    rd_req = 1'b1; ptr_load = 1'b1; ptr_value = 2'd0;
    @(negedge clk); rd_req = 1'b0; ptr_load = 1'b0;
    check("R4 read+load ptr", ptr, 0);

    // Sweep every mode x segment code
    for (int m = 0; m < 5; m++) begin
      for (int s = 0; s < 5; s++) begin
        logic [127:0] blk;
        logic [127:0] res;
        logic [3:0]   rel;
        logic [3:0]   seen;
        int           order [4];
        mode = 3'(m); seg_size = 3'(s); irq_en = 1'((m + s) % 2);
        rel = rel_model(m, s);
        set_ptr(2'd2);
        for (int i = 0; i < 4; i++) begin
          logic [31:0] w;
          w = 32'h1000_0000 * (m + 1) + 32'h0010_0000 * (s + 1) + 32'(i * 7 + 3);
          blk[((i + 2) % 4) * 32 +: 32] = w;
          write_word(w);
        end
        check("R2 wrap ptr", ptr, 2);
        // R6 start
        @(negedge clk); start = 1'b1;
        #1;
        check("R6 eng_start", eng_start, 1);
        check("R6 eng_block", eng_block, blk);
        @(negedge clk); start = 1'b0;
        check("R6 busy", busy, 1);
        // R5 write while busy
        check("R5 wr_ready", wr_ready, 0);
        @(negedge clk); wr_valid = 1'b1; wr_data = 32'hDEAD_BEEF; start = 1'b1;
        #1;
        check("R6 start ignored", eng_start, 0);
        @(negedge clk); wr_valid = 1'b0; start = 1'b0;
        check("R5 ptr unchanged", ptr, 2);
        check("R5 words unchanged", eng_block, blk);
        // R7 result
        res = ~{blk[63:0], blk[127:64]} ^ 128'(m * 5 + s);
        @(negedge clk); eng_done = 1'b1; eng_result = res;
        @(negedge clk); eng_done = 1'b0;
        check("R7 flag", done_flag, 1);
        check("R7 busy clear", busy, 0);
        check("R10 irq", irq, irq_en);
        // R8/R9 out-of-order read-out: 3,1,1,2,0
        order = '{3, 1, 2, 0};
        seen = '0;
        for (int k = 0; k < 4; k++) begin
          set_ptr(2'(order[k]));
          read_word("R8 output word", res[order[k] * 32 +: 32]);
          seen[order[k]] = 1'b1;
          if (k == 1) begin
            set_ptr(2'(order[k]));
            read_word("R9 re-read word", res[order[k] * 32 +: 32]);
          end
          check(((seen & rel) == rel) ? "R8 flag clear" : "R9 flag held",
                done_flag, ((seen & rel) != rel));
          check("R10 irq", irq, ((seen & rel) != rel) && irq_en);
        end
      end
    end

    // R9 mask emptied on new result: read all, then new result needs all again
    mode = 3'd0; seg_size = 3'd0;
    @(negedge clk); eng_done = 1'b1; eng_result = 128'h0;
    @(negedge clk); eng_done = 1'b0;
    set_ptr(2'd0);
    for (int i = 0; i < 3; i++) read_word("R9 fresh read", 32'h0);
    check("R9 fresh mask holds flag", done_flag, 1);
    read_word("R9 last word", 32'h0);
    check("R8 ecb clear", done_flag, 0);

    summary();
  end
endmodule